// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Beat Order

This block produces the address for a short burst on a synchronous memory. One of two independent active-low strobes captures an external address into a base register and clears a beat counter. Each later rising edge with the active-low advance input asserted moves the counter on by one beat. A high advance input makes that edge a wait cycle.

Only the low `BEAT_W` address bits are generated internally. With the default `BEAT_W = 2` the burst is four beats long. The upper bits keep the loaded value for as long as the burst runs. A static order input selects how the generated bits are formed. In interleaved order they are the start bits XOR the beat index. In linear order they are the start bits plus the beat index, wrapping within the aligned group.

The memory array, the data path and the write control belong to the surrounding design.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low and after its release with no strobe, `addr_q` is all zeros and `beat_idx` is 0.
- R2: A rising edge with `ld_a_n` low copies `ext_addr` into `addr_q` and sets `beat_idx` to 0.
- R3: A rising edge with `ld_b_n` low, alone or together with `ld_a_n` low, behaves exactly like R2.
- R4: With `order_sel` = 1 (interleaved), the low two bits of `addr_q` equal the loaded start bits XOR `beat_idx`. For example, a start of 01 gives 01, 00, 11, 10.
- R5: With `order_sel` = 0 (linear), the low two bits of `addr_q` equal the start bits plus `beat_idx`, modulo 4. For example, a start of 10 gives 10, 11, 00, 01.
- R6: Between loads, bits above bit 1 of `addr_q` keep the value captured at the last load.
- R7: A rising edge with both strobes high and `adv_n` high leaves `addr_q` and `beat_idx` unchanged.
- R8: When a strobe and `adv_n` are both low at the same edge, the load wins: the new address appears with `beat_idx` = 0.
- R9: An advance from `beat_idx` = 3 returns it to 0, and the sequence repeats within the same aligned group of four.
- R10: `ext_addr` has no effect on `addr_q` at an edge where both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; all inputs are sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | ADDR_W | External start address |
| ld_a_n | input | 1 | First load strobe, active low |
| ld_b_n | input | 1 | Second load strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low; high means wait |
| order_sel | input | 1 | Static beat order: 0 = linear, 1 = interleaved |
| addr_q | output | ADDR_W | Current burst address (upper bits held, low bits generated) |
| beat_idx | output | BEAT_W | Beat index since the last load |

## Verification
The bench builds the block with its defaults, `ADDR_W = 16` and `BEAT_W = 2`. This is a four-beat burst with fourteen held upper bits, so every start offset of the aligned group can be reached in both orders within a few cycles. Runs of more than four advances reach the wrap point. Wait cycles, simultaneous strobe and advance, and a changing `ext_addr` without a strobe each land on the next edge. The scoreboard compares both outputs against a model built from the requirements.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;

endpackage

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv_n,
   output logic [BEAT_W-1:0] beat_q
);

   localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};
   localparam logic [BEAT_W-1:0] ONE       = BEAT_W'(1);

   if (BEAT_W < 1) begin : g_bad_beat_w
      $error("bsq_beat_ctr: BEAT_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (load) begin
         beat_q <= '0;
      end else if (!adv_n) begin
         beat_q <= beat_q + ONE;
      end
   end

   a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && adv_n) |=> $stable(beat_q));

   a_r8_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (beat_q == '0));

   a_r9_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv_n && beat_q == LAST_BEAT) |=> (beat_q == '0));

   a_r4_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv_n) |=> (beat_q == $past(beat_q) + ONE));

endmodule

// File: rtl/bsq_base_reg.sv
module bsq_base_reg #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);

   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("bsq_base_reg: ADDR_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end

   a_r10_no_load_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/bsq_low_map.sv
module bsq_low_map
   import bsq_pkg::*;
#(
   parameter int BEAT_W = 2
) (
   input  logic [BEAT_W-1:0] start,
   input  logic [BEAT_W-1:0] beat,
   input  order_e            order,
   output logic [BEAT_W-1:0] low
);

   logic [BEAT_W-1:0] lin_low;
   logic [BEAT_W-1:0] ilv_low;

   // Interleaved: each bit is flipped independently by the matching beat bit.
   for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
      assign ilv_low[b] = start[b] ^ beat[b];
   end

   // Linear: wrapping add within the aligned group.
   if (BEAT_W == 1) begin : g_lin_one
      assign lin_low = start ^ beat;
   end else begin : g_lin_add
      assign lin_low = start + beat;
   end

   always_comb begin
      low = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bsq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              ld_a_n,
   input  logic              ld_b_n,
   input  logic              adv_n,
   input  logic              order_sel,
   output logic [ADDR_W-1:0] addr_q,
   output logic [BEAT_W-1:0] beat_idx
);

   localparam int HI_W = ADDR_W - BEAT_W;
   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   if (BEAT_W < 1 || BEAT_W >= ADDR_W) begin : g_bad_split
      $error("burst_addr_seq: need 1 <= BEAT_W < ADDR_W");
   end

   logic              load;
   logic [ADDR_W-1:0] base_q;
   logic [BEAT_W-1:0] low;
   order_e            order;

   assign load  = ~ld_a_n | ~ld_b_n;
   assign order = order_e'(order_sel);

   bsq_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .d     (ext_addr),
      .q     (base_q)
   );

   bsq_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .adv_n  (adv_n),
      .beat_q (beat_idx)
   );

   bsq_low_map #(.BEAT_W(BEAT_W)) u_map (
      .start (base_q[BEAT_W-1:0]),
      .beat  (beat_idx),
      .order (order),
      .low   (low)
   );

   assign addr_q = {base_q[ADDR_W-1:BEAT_W], low};

   a_r2_load_takes_addr: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (addr_q == $past(ext_addr) && beat_idx == '0));

   a_r6_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (addr_q[ADDR_W-1:BEAT_W] == $past(addr_q[ADDR_W-1:BEAT_W])));

   a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv_n && !order_sel && !$past(order_sel)) |=>
      (addr_q[BEAT_W-1:0] == $past(addr_q[BEAT_W-1:0]) + ONE));

   a_r4_interleave_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv_n && order_sel) |=>
      ((addr_q[BEAT_W-1:0] ^ $past(addr_q[BEAT_W-1:0])) ==
       (beat_idx ^ $past(beat_idx))));

   a_r7_wait_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && adv_n && $stable(order_sel)) |=> $stable(addr_q));

   initial begin
      a_r1_split_ok: assert (HI_W >= 1);
   end

endmodule

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;

   localparam int ADDR_W = 16;
   localparam int BEAT_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] ext_addr = '0;
   logic              ld_a_n = 1'b1;
   logic              ld_b_n = 1'b1;
   logic              adv_n = 1'b1;
   logic              order_sel = 1'b1;
   logic [ADDR_W-1:0] addr_q;
   logic [BEAT_W-1:0] beat_idx;

   burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_addr  (ext_addr),
      .ld_a_n    (ld_a_n),
      .ld_b_n    (ld_b_n),
      .adv_n     (adv_n),
      .order_sel (order_sel),
      .addr_q    (addr_q),
      .beat_idx  (beat_idx)
   );

   always #2 clk = ~clk;

   typedef struct {
      int                due;
      logic [ADDR_W-1:0] addr;
      logic [BEAT_W-1:0] beat;
      string             tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   logic [ADDR_W-1:0] m_base = '0;
   logic [BEAT_W-1:0] m_beat = '0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [ADDR_W-1:0] model_addr(input logic ord);
      logic [BEAT_W-1:0] lo;
      lo = ord ? (m_base[BEAT_W-1:0] ^ m_beat) : (m_base[BEAT_W-1:0] + m_beat);
      return {m_base[ADDR_W-1:BEAT_W], lo};
   endfunction

   task automatic step(input logic a_n, input logic b_n, input logic av_n,
                       input logic [ADDR_W-1:0] ea, input logic ord,
                       input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      ld_a_n = a_n; ld_b_n = b_n; adv_n = av_n; ext_addr = ea; order_sel = ord;
      if (!a_n || !b_n) begin
         m_base = ea;
         m_beat = '0;
      end else if (!av_n) begin
         m_beat = m_beat + 1'b1;
      end
      e.due  = cyc + 1;
      e.addr = model_addr(ord);
      e.beat = m_beat;
      e.tag  = tag;
      q.push_back(e);
   endtask

   always @(posedge clk) begin
      #2;
      while (q.size() > 0 && q[0].due <= cyc) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (addr_q !== e.addr || beat_idx !== e.beat) begin
            n_fail++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     e.tag, addr_q, beat_idx, e.addr, e.beat);
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      n_chk++;
      if (addr_q !== '0 || beat_idx !== '0) begin
         n_fail++;
         $display("FAIL R1: addr=%h beat=%0d expected addr=0000 beat=0", addr_q, beat_idx);
      end
      @(posedge clk);
      #1 rst_n = 1'b1;
      step(1, 1, 1, 16'h1234, 1, "R1 idle");

      // Interleaved from start 01, five advances to cross the wrap.
      step(0, 1, 1, 16'hABC1, 1, "R2 load A");
      for (int i = 0; i < 5; i++) step(1, 1, 0, 16'hFFFF, 1, "R4 R6 R9 interleave");

      // Waits with a changing external address.
      step(1, 1, 1, 16'h0000, 1, "R7 R10 wait");
      step(1, 1, 1, 16'h7777, 1, "R7 R10 wait");
      step(1, 1, 0, 16'h3333, 1, "R4 R10 resume");

      // Linear from start 10 via strobe B, six advances.
      step(1, 0, 1, 16'h5552, 0, "R3 load B");
      for (int i = 0; i < 6; i++) step(1, 1, 0, 16'h0F0F, 0, "R5 R6 R9 linear");
      step(1, 1, 1, 16'hAAAA, 0, "R7 linear wait");

      // Load wins over advance, both strobes together.
      step(0, 0, 0, 16'h8003, 1, "R8 R3 load over adv");
      for (int i = 0; i < 4; i++) step(1, 1, 0, 16'h1111, 1, "R4 interleave 11");
      step(0, 1, 0, 16'h4001, 0, "R8 load over adv linear");
      for (int i = 0; i < 4; i++) step(1, 1, 0, 16'h2222, 0, "R5 linear 01");
      step(1, 1, 1, 16'h0000, 0, "R7 final wait");

      repeat (3) @(posedge clk);
      #3;
      if (q.size() != 0) begin
         n_chk++;
         n_fail++;
         $display("FAIL scoreboard: %0d items left, expected 0", q.size());
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule